// File: doc/BRIEF.md
# Processor Slot Hot-Plug Register Window

This block gives a host a small register window for managing a parameterised number of processor slots. The host first stores a slot index into a selector register. After that, every other access refers to the selected slot. Through the window the host can:

- read the slot's enabled flag and its pending insert and remove flags;
- acknowledge those events;
- issue a command that scans for the lowest-numbered slot with a pending event and selects it;
- read the slot's 64-bit architectural identifier as two 32-bit halves;
- deposit two 32-bit status words for the operating system. Storing the second word emits a one-cycle notification.

Platform logic drives the per-slot enabled level, single-cycle insert and remove requests, and the identifier values. The window is 12 bytes wide and little-endian. Registers at offsets 0x0 and 0x8 are dword registers. Registers at offsets 0x4 and 0x5 are byte registers. A selector that points past the last slot silences the window until a valid index is stored again.

Top module: `cpu_slot_regs`

## Requirements
- R1: Offsets are in bytes over a 12-byte window, and every dword value maps its bit 0 to the lowest-addressed byte. Registers are decoded only at their own width: dword at 0x0 and 0x8, byte at 0x4 and 0x5. Any other offset or width reads as 0 and ignores writes. Offset 0x5 is write-only and reads as 0.
- R2: A dword write at 0x0 always stores the selector. While the stored selector is NUM_SLOTS or larger, every read returns 0 and writes to 0x4, 0x5 and 0x8 change nothing.
- R3: Power-on reset (por_n low) sets the selector to 0. The ordinary reset (rst_n low) leaves the selector unchanged and clears the last command to 0, all pending flags and both status words.
- R4: A byte read at 0x4 returns bit 0 = selected slot enabled, bit 1 = insert pending, bit 2 = remove pending, and zeros in bits 7:3.
- R5: A byte write at 0x4 clears the selected slot's insert flag when data bit 1 is 1 and its remove flag when data bit 2 is 1. Bit 0 has no effect.
- R6: A byte write of value 0 at 0x5 selects the lowest-indexed slot with either flag pending. If no slot has a flag pending, the selector and all flags stay unchanged.
- R7: A dword read at 0x8 returns the selector after command 0, the low 32 bits of the selected slot's identifier after command 3, and 0 after any other command.
- R8: A dword read at 0x0 returns the upper 32 bits of the selected slot's identifier after command 3 and 0 after any other command.
- R9: A dword write at 0x8 stores the event word after command 1. After command 2 it stores the status word and raises ost_pulse for one cycle, with both words valid on the outputs in that cycle. After any other command it changes nothing.
- R10: An insert or remove request input sets the slot's flag at the next edge. A request wins over a clear in the same cycle.
- R11: Read data is registered. It appears one cycle after bus_rd and is 0 in every cycle not following a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, initialises the selector |
| rst_n | input | 1 | Ordinary reset, active low, asynchronous |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Byte offset within the window |
| bus_dword | input | 1 | 1 = dword access, 0 = byte access |
| bus_wdata | input | 32 | Write data, byte accesses use bits 7:0 |
| bus_rdata | output | 32 | Registered read data |
| slot_enabled | input | NUM_SLOTS | Per-slot enabled level |
| ins_req | input | NUM_SLOTS | Per-slot insert event request pulse |
| rem_req | input | NUM_SLOTS | Per-slot remove event request pulse |
| slot_id | input | NUM_SLOTS*64 | Per-slot 64-bit identifiers, slot i at bits 64*i+63:64*i |
| ost_pulse | output | 1 | One-cycle notification after a status-word store |
| ost_event | output | 32 | Stored event word |
| ost_status | output | 32 | Stored status word |

## Verification
Every store takes effect at the clock edge that samples the write strobe. A register write therefore shows up in read data two edges after it is issued: one edge for the store and one for the registered read. The notification pulse and the new status word appear together, one edge after the status-word write. Insert and remove requests are visible in the flags one edge after they are raised.

The bench drives inputs on falling edges and lets a behavioural model advance on each rising edge. It compares read data, pulse and both status words on every falling edge, so each result is checked in exactly the cycle it is due. The enumeration pass also checks the number of present slots and the zero that marks the end of the scan.

// File: rtl/cpu_slot_regs.sv
module cpu_slot_regs #(
  parameter int NUM_SLOTS = 8
) (
  input  logic                    clk,
  input  logic                    por_n,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [3:0]              bus_addr,
  input  logic                    bus_dword,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic [NUM_SLOTS-1:0]    slot_enabled,
  input  logic [NUM_SLOTS-1:0]    ins_req,
  input  logic [NUM_SLOTS-1:0]    rem_req,
  input  logic [NUM_SLOTS*64-1:0] slot_id,
  output logic                    ost_pulse,
  output logic [31:0]             ost_event,
  output logic [31:0]             ost_status
);
  localparam int ID_W  = 64;
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam logic [7:0] CMD_SCAN = 8'd0;
  localparam logic [7:0] CMD_EVT  = 8'd1;
  localparam logic [7:0] CMD_STS  = 8'd2;
  localparam logic [7:0] CMD_ID   = 8'd3;

  logic [31:0]          sel_q;
  logic [7:0]           cmd_q;
  logic [NUM_SLOTS-1:0] ins_q, rem_q;
  logic [IDX_W-1:0]     hit_idx;
  logic                 hit;
  logic [31:0]          rd_mux;

  wire                   sel_ok   = sel_q < 32'(NUM_SLOTS);
  wire [IDX_W-1:0]       idx      = sel_q[IDX_W-1:0];
  wire [ID_W-1:0]        cur_id   = slot_id[idx*ID_W +: ID_W];
  wire [NUM_SLOTS-1:0]   sel_1hot = NUM_SLOTS'(1) << idx;

  wire a_sel  = bus_dword  && bus_addr == 4'h0;
  wire a_ctl  = !bus_dword && bus_addr == 4'h4;
  wire a_cmd  = !bus_dword && bus_addr == 4'h5;
  wire a_data = bus_dword  && bus_addr == 4'h8;

  wire wr_ok    = bus_wr && sel_ok;
  wire do_scan  = wr_ok && a_cmd && bus_wdata[7:0] == CMD_SCAN;
  wire do_evt   = wr_ok && a_data && cmd_q == CMD_EVT;
  wire do_sts   = wr_ok && a_data && cmd_q == CMD_STS;

  wire [NUM_SLOTS-1:0] clr_ins = (wr_ok && a_ctl && bus_wdata[1]) ? sel_1hot : '0;
  wire [NUM_SLOTS-1:0] clr_rem = (wr_ok && a_ctl && bus_wdata[2]) ? sel_1hot : '0;

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (ins_q[i] || rem_q[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                sel_q <= '0;
    else if (bus_wr && a_sel)  sel_q <= bus_wdata;
    else if (do_scan && hit)   sel_q <= 32'(hit_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= CMD_SCAN;
      ins_q <= '0;
      rem_q <= '0;
    end else begin
      if (wr_ok && a_cmd) cmd_q <= bus_wdata[7:0];
      ins_q <= (ins_q & ~clr_ins) | ins_req;
      rem_q <= (rem_q & ~clr_rem) | rem_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ost_event  <= '0;
      ost_status <= '0;
      ost_pulse  <= 1'b0;
    end else begin
      if (do_evt) ost_event <= bus_wdata;
      if (do_sts) ost_status <= bus_wdata;
      ost_pulse <= do_sts;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (a_sel && cmd_q == CMD_ID)
      rd_mux = cur_id[63:32];
    else if (a_ctl)
      rd_mux = {29'd0, rem_q[idx], ins_q[idx], slot_enabled[idx]};
    else if (a_data && cmd_q == CMD_SCAN)
      rd_mux = sel_q;
    else if (a_data && cmd_q == CMD_ID)
      rd_mux = cur_id[31:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                bus_rdata <= '0;
    else if (bus_rd && sel_ok) bus_rdata <= rd_mux;
    else                       bus_rdata <= '0;
  end

  assert_bad_sel_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !sel_ok) |=> bus_rdata == 32'd0);

  assert_bad_sel_holds_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ok |=> ($stable(cmd_q) && $stable(ost_event) && $stable(ost_status)));

  assert_scan_miss_keeps_sel_R6: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (do_scan && (ins_q | rem_q) == '0) |=> $stable(sel_q));

  assert_scan_hit_valid_R6: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (do_scan && (ins_q | rem_q) != '0) |=> (sel_q < 32'(NUM_SLOTS)));

  assert_pulse_after_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ost_pulse |-> $past(bus_wr && bus_dword && bus_addr == 4'h8 && cmd_q == CMD_STS));

  assert_idle_rdata_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == 32'd0);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_flag_chk
    assert_ins_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ins_req[g] |=> ins_q[g]);
    assert_rem_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rem_req[g] |=> rem_q[g]);
  end
endmodule

// File: tb/cpu_slot_regs_bench.sv
`timescale 1ns/1ps
module cpu_slot_regs_bench;
  localparam int N = 8;
  localparam logic [N-1:0] EN_PAT = 8'b1011_0101;

  logic clk = 0, por_n = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0, bus_dword = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [N-1:0] slot_enabled = EN_PAT, ins_req = 0, rem_req = 0;
  logic [N*64-1:0] slot_id;
  logic ost_pulse;
  logic [31:0] ost_event, ost_status;

  int vectors = 0, miscompares = 0;
  string cur_req = "R3";
  bit cmp_en = 0, done = 0;

  always #2 clk = ~clk;

  cpu_slot_regs #(.NUM_SLOTS(N)) u_cpu_slot_regs (
    .clk, .por_n, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_dword, .bus_wdata,
    .bus_rdata, .slot_enabled, .ins_req, .rem_req, .slot_id,
    .ost_pulse, .ost_event, .ost_status);

  function automatic logic [63:0] id_of(int i);
    return {32'hC0DE_0000 + 32'(i), 32'h0010_0000 + 32'(i) * 32'h11};
  endfunction

  initial for (int i = 0; i < N; i++) slot_id[i*64 +: 64] = id_of(i);

  // behavioural reference
  int m_sel = 0, m_cmd = 0;
  bit m_ins[N], m_rem[N];
  logic [31:0] m_rd = 0, m_ev = 0, m_st = 0;
  bit m_pulse = 0;

  always @(posedge clk) begin
    bit ok;
    int nsel, found;
    logic [31:0] r;
    logic [63:0] id;
    ok = (m_sel >= 0) && (m_sel < N);
    id = ok ? id_of(m_sel) : 64'd0;
    r = 0;
    nsel = m_sel;
    if (bus_rd && ok) begin
      if (bus_dword && bus_addr == 0 && m_cmd == 3) r = id[63:32];
      else if (!bus_dword && bus_addr == 4) r = {29'd0, m_rem[m_sel], m_ins[m_sel], slot_enabled[m_sel]};
      else if (bus_dword && bus_addr == 8 && m_cmd == 0) r = m_sel;
      else if (bus_dword && bus_addr == 8 && m_cmd == 3) r = id[31:0];
    end
    if (!por_n) nsel = 0;
    else if (bus_wr && bus_dword && bus_addr == 0) nsel = int'(bus_wdata);
    else if (bus_wr && ok && !bus_dword && bus_addr == 5 && bus_wdata[7:0] == 0) begin
      found = -1;
      for (int i = 0; i < N; i++) if (found < 0 && (m_ins[i] || m_rem[i])) found = i;
      if (found >= 0) nsel = found;
    end
    if (!rst_n) begin
      m_cmd = 0; m_rd = 0; m_ev = 0; m_st = 0; m_pulse = 0;
      for (int i = 0; i < N; i++) begin m_ins[i] = 0; m_rem[i] = 0; end
    end else begin
      m_pulse = 0;
      if (bus_wr && ok) begin
        if (!bus_dword && bus_addr == 4) begin
          if (bus_wdata[1]) m_ins[m_sel] = 0;
          if (bus_wdata[2]) m_rem[m_sel] = 0;
        end
        if (bus_dword && bus_addr == 8 && m_cmd == 1) m_ev = bus_wdata;
        if (bus_dword && bus_addr == 8 && m_cmd == 2) begin m_st = bus_wdata; m_pulse = 1; end
        if (!bus_dword && bus_addr == 5) m_cmd = int'(bus_wdata[7:0]);
      end
      for (int i = 0; i < N; i++) begin
        if (ins_req[i]) m_ins[i] = 1;
        if (rem_req[i]) m_rem[i] = 1;
      end
      m_rd = r;
    end
    m_sel = nsel;
  end

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  always @(negedge clk) if (cmp_en && !done) begin
    check(cur_req, "rdata", bus_rdata, m_rd);
    check(cur_req, "ost_pulse", 32'(ost_pulse), 32'(m_pulse));
    check(cur_req, "ost_event", ost_event, m_ev);
    check(cur_req, "ost_status", ost_status, m_st);
  end

  task automatic wr(logic [3:0] a, bit dw, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_dword = dw; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, bit dw, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; bus_dword = dw;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic req(logic [N-1:0] ins, logic [N-1:0] rem);
    @(negedge clk); ins_req = ins; rem_req = rem;
    @(negedge clk); ins_req = 0; rem_req = 0;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int present, iter;
    repeat (3) @(negedge clk);
    por_n = 1; rst_n = 1;
    @(posedge clk); cmp_en = 1;

    cur_req = "R3"; rd(4'h8, 1, d);
    check("R3", "selector after power-on", d, 0);

    cur_req = "R4";
    for (int i = 0; i < N; i++) begin wr(4'h0, 1, i); rd(4'h4, 0, d); end

    cur_req = "R7";
    wr(4'h0, 1, 5); wr(4'h5, 0, 3); rd(4'h8, 1, d);
    check("R7", "id low", d, id_of(5)[31:0]);
    cur_req = "R8"; rd(4'h0, 1, d);
    check("R8", "id high", d, id_of(5)[63:32]);
    wr(4'h5, 0, 7); rd(4'h0, 1, d); rd(4'h8, 1, d);

    cur_req = "R10";
    req(8'b0010_0000, 8'b0000_0100);
    wr(4'h0, 1, 5); rd(4'h4, 0, d);
    check("R10", "slot5 status", d, 32'h3);
    @(negedge clk); bus_wr = 1; bus_addr = 4; bus_dword = 0; bus_wdata = 32'h2; ins_req = 8'b0010_0000;
    @(negedge clk); bus_wr = 0; ins_req = 0;
    rd(4'h4, 0, d);

    cur_req = "R5"; wr(4'h4, 0, 32'h1); rd(4'h4, 0, d);
    check("R5", "bit0 write no effect", d, 32'h3);

    cur_req = "R6";
    wr(4'h5, 0, 0); rd(4'h8, 1, d);
    check("R6", "lowest pending slot", d, 2);
    wr(4'h4, 0, 32'h6); wr(4'h5, 0, 0); rd(4'h8, 1, d);
    check("R6", "next pending slot", d, 5);
    wr(4'h4, 0, 32'h6); wr(4'h0, 1, 3); wr(4'h5, 0, 0); rd(4'h8, 1, d);
    check("R6", "no pending keeps selector", d, 3);

    cur_req = "R9";
    wr(4'h5, 0, 1); wr(4'h8, 1, 32'h0000_0103);
    wr(4'h5, 0, 2); wr(4'h8, 1, 32'h0000_0001);
    wr(4'h5, 0, 0); wr(4'h8, 1, 32'hDEAD_BEEF);

    cur_req = "R1";
    wr(4'h5, 0, 3);
    rd(4'h4, 1, d); rd(4'h5, 0, d); rd(4'h1, 0, d); rd(4'h0, 0, d); rd(4'hC, 1, d);
    wr(4'h5, 1, 32'h1); rd(4'h8, 1, d);
    check("R1", "dword write at byte reg ignored", d, id_of(3)[31:0]);

    cur_req = "R2";
    wr(4'h0, 1, 100); rd(4'h4, 0, d);
    check("R2", "out of range status", d, 0);
    wr(4'h5, 0, 1); wr(4'h8, 1, 32'h55); rd(4'h8, 1, d);
    wr(4'h0, 1, 3); rd(4'h8, 1, d);
    check("R2", "command kept at 3", d, id_of(3)[31:0]);

    cur_req = "R3";
    wr(4'h0, 1, 6);
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    rd(4'h8, 1, d);
    check("R3", "selector kept over reset", d, 6);

    cur_req = "R11";
    present = 0; iter = 0;
    wr(4'h0, 1, 0); wr(4'h5, 0, 0);
    do begin
      rd(4'h4, 0, d);
      if (d[0]) present++;
      iter++;
      wr(4'h0, 1, iter);
      rd(4'h8, 1, d);
    end while (d != 0 && iter < 64);
    check("R2", "enumeration end data", d, 0);
    check("R4", "present count", present, $countones(EN_PAT));
    check("R2", "iterator at end", iter, N);
    wr(4'h0, 1, 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule